// File: doc/BRIEF.md
# Programmable Divider and Phase Comparator Core

This block is the digital heart of a frequency synthesiser loop. It receives two single-cycle strobes in the system clock domain: one for every period of the local oscillator after the external fixed prescaler, and one for every period of the reference oscillator. A 15-bit programmable counter divides the oscillator strobes by a ratio N. A fixed counter divides the reference strobes down to the comparison rate; with the default ratio of 512, a 4 MHz reference gives 7.8125 kHz. A tri-state phase-frequency detector compares the two divided event streams. It drives pump-up and pump-down requests toward an external charge pump. It also raises a lock flag once the loop has settled. The resulting oscillator frequency is N × 16 × the comparison frequency.

Control pins select the high or low pump current and turn the pump off. A further pin turns the tuning-voltage drive amplifier off. In test mode the two comparator inputs are sent to a pair of port pins in place of their normal drive. The strobes are free-running event inputs. They have no valid/ready handshake and cannot be back-pressured: every strobe is consumed in the cycle it arrives. All other pins are plain levels.

Top module: `synth_phase_core`

## Requirements
- R1: The reference divider emits one comparison event for every REF_DIV reference strobes (default 512).
- R2: The programmable divider emits one divided event for every N oscillator strobes, where N is the 15-bit ratio input. Ratios 0 and 1 act as 2.
- R3: A change of the ratio input takes effect only at the divider's terminal count. The period in progress keeps the old length.
- R4: A comparison event sets the detector's up state and a divided event sets its down state. When both states are high they are both cleared on the next cycle. An event that arrives in that clearing cycle is kept. Two events in the same cycle therefore produce equal up and down pulses.
- R5: pump_up and pump_dn follow the detector state one cycle later. While pump_off is 1 they are both held at 0.
- R6: cp_hi follows cur_hi (1 selects the high pump current, 0 the low one). drv_off follows drv_dis.
- R7: With test_en at 1, p6_out carries the comparison event and p7_out carries the divided event. With test_en at 0 they pass p6_drv and p7_drv.
- R8: locked rises after LOCK_CNT consecutive comparison periods in which no up-only or down-only pulse lasted longer than LOCK_WIN cycles.
- R9: locked falls on the cycle after an up-only or down-only pulse reaches LOCK_WIN+1 cycles.
- R10: While rst_n is low, pump_up, pump_dn and locked are 0 and both dividers restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_tick | input | 1 | One strobe per prescaled oscillator period |
| ref_tick | input | 1 | One strobe per reference period |
| n_ratio | input | 15 | Programmable division ratio N |
| cur_hi | input | 1 | Pump current select, 1 = high |
| pump_off | input | 1 | Disables both pump requests |
| drv_dis | input | 1 | Turns the drive amplifier off |
| test_en | input | 1 | Routes comparator inputs to the port pins |
| p6_drv | input | 1 | Normal level for port 6 |
| p7_drv | input | 1 | Normal level for port 7 |
| pump_up | output | 1 | Charge-pump source request |
| pump_dn | output | 1 | Charge-pump sink request |
| cp_hi | output | 1 | High-current select to the pump |
| drv_off | output | 1 | Drive amplifier disable |
| p6_out | output | 1 | Port 6 level |
| p7_out | output | 1 | Port 7 level |
| locked | output | 1 | Phase and frequency lock flag |

## Verification
The comparison event and the divided event can arrive in the same cycle. This happens whenever the loop is exactly aligned, and it also occurs during the clearing cycle of the detector. The bench provokes it by clocking both dividers from strobes in a common phase with ratios whose products are equal. In every such run, pump_up and pump_dn must never differ and locked must rise. Runs with slightly mismatched ratios provide the contrast: there the one-sided pulses grow, and locked must stay low.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int unsigned RATIO_W = 15;

  function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] n);
    return (n < 2) ? RATIO_W'(2) : n;
  endfunction
endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
  parameter int unsigned REF_DIV = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic cmp_ev
);
  localparam int unsigned CW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      cmp_ev <= 1'b0;
    end else begin
      cmp_ev <= 1'b0;
      if (tick) begin
        if (cnt == LAST) begin
          cnt    <= '0;
          cmp_ev <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1: at least two strobes per period, so events never sit back to back
  a_r1_event_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ev |=> !cmp_ev);
endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div
  import synth_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [RATIO_W-1:0] n_in,
  output logic               div_ev
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] n_cur;
  logic               at_term;

  assign at_term = tick && (cnt == n_cur - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      n_cur  <= clamp_ratio(n_in);
      div_ev <= 1'b0;
    end else begin
      div_ev <= at_term;
      if (at_term) begin
        cnt   <= '0;
        n_cur <= clamp_ratio(n_in);
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the effective ratio never drops below two
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    div_ev |=> !div_ev);
  // R3: the ratio in use changes only across a terminal count
  a_r3_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    !at_term |=> $stable(n_cur));
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,
  input  logic div_ev,
  output logic up_q,
  output logic dn_q
);
  logic clr;
  assign clr = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= (up_q & ~clr) | ref_ev;
      dn_q <= (dn_q & ~clr) | div_ev;
    end
  end

  // R4: both high is resolved on the next cycle unless fresh events arrive together
  a_r4_overlap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && !(ref_ev && div_ev)) |=> !(up_q && dn_q));
  a_r4_ref_sets_up: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ev |=> up_q);
endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
  parameter int unsigned LOCK_WIN = 4,
  parameter int unsigned LOCK_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_q,
  input  logic dn_q,
  input  logic cmp_ev,
  output logic locked
);
  localparam int unsigned WW = $clog2(LOCK_WIN + 2);
  localparam int unsigned GW = $clog2(LOCK_CNT + 1);
  localparam logic [WW-1:0] WMAX = WW'(LOCK_WIN);
  localparam logic [GW-1:0] GMAX = GW'(LOCK_CNT);

  logic          one_sided;
  logic          excess;
  logic [WW-1:0] wcnt;
  logic [GW-1:0] good;
  logic          bad;

  assign one_sided = up_q ^ dn_q;
  assign excess    = one_sided && (wcnt == WMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt   <= '0;
      good   <= '0;
      bad    <= 1'b0;
      locked <= 1'b0;
    end else begin
      if (!one_sided)         wcnt <= '0;
      else if (wcnt != WMAX)  wcnt <= wcnt + 1'b1;

      if (cmp_ev) bad <= 1'b0;
      else        bad <= bad | excess;

      if (excess) begin
        good   <= '0;
        locked <= 1'b0;
      end else if (cmp_ev) begin
        if (bad) begin
          good <= '0;
        end else if (good != GMAX) begin
          good <= good + 1'b1;
          if (good == GMAX - 1'b1) locked <= 1'b1;
        end
      end
    end
  end

  // R9: a too-wide one-sided pulse removes lock at once
  a_r9_drop_on_excess: assert property (@(posedge clk) disable iff (!rst_n)
    excess |=> !locked);
  // R8: lock is only granted at the close of a comparison period
  a_r8_rise_at_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmp_ev));
endmodule

// File: rtl/synth_phase_core.sv
module synth_phase_core
  import synth_pkg::*;
#(
  parameter int unsigned REF_DIV  = 512,
  parameter int unsigned LOCK_WIN = 4,
  parameter int unsigned LOCK_CNT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_tick,
  input  logic               ref_tick,
  input  logic [RATIO_W-1:0] n_ratio,
  input  logic               cur_hi,
  input  logic               pump_off,
  input  logic               drv_dis,
  input  logic               test_en,
  input  logic               p6_drv,
  input  logic               p7_drv,
  output logic               pump_up,
  output logic               pump_dn,
  output logic               cp_hi,
  output logic               drv_off,
  output logic               p6_out,
  output logic               p7_out,
  output logic               locked
);
  logic cmp_ev, div_ev, up_q, dn_q;

  synth_ref_div #(.REF_DIV(REF_DIV)) u_ref (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .cmp_ev(cmp_ev));

  synth_prog_div u_prog (
    .clk(clk), .rst_n(rst_n), .tick(lo_tick), .n_in(n_ratio), .div_ev(div_ev));

  synth_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_ev(cmp_ev), .div_ev(div_ev),
    .up_q(up_q), .dn_q(dn_q));

  synth_lock_det #(.LOCK_WIN(LOCK_WIN), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk(clk), .rst_n(rst_n), .up_q(up_q), .dn_q(dn_q),
    .cmp_ev(cmp_ev), .locked(locked));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
    end else begin
      pump_up <= up_q & ~pump_off;
      pump_dn <= dn_q & ~pump_off;
    end
  end

  assign cp_hi   = cur_hi;
  assign drv_off = drv_dis;
  assign p6_out  = test_en ? cmp_ev : p6_drv;
  assign p7_out  = test_en ? div_ev : p7_drv;

  // R5: a disabled pump issues no request on the following cycle
  a_r5_pump_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pump_off |=> !(pump_up || pump_dn));
  // R5: requests track detector state with one register of delay
  a_r5_up_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !pump_off) |=> pump_up);
endmodule

// File: tb/synth_phase_core_bench.sv
module synth_phase_core_bench;
  localparam int REF_DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_tick = 1'b0, ref_tick = 1'b0;
  logic [14:0] n_ratio = 15'd8;
  logic cur_hi = 0, pump_off = 0, drv_dis = 0, test_en = 0, p6_drv = 0, p7_drv = 0;
  logic pump_up, pump_dn, cp_hi, drv_off, p6_out, p7_out, locked;

  always #5 clk = ~clk;

  synth_phase_core #(.REF_DIV(REF_DIV), .LOCK_WIN(2), .LOCK_CNT(6)) u_synth_phase_core (
    .clk(clk), .rst_n(rst_n), .lo_tick(lo_tick), .ref_tick(ref_tick),
    .n_ratio(n_ratio), .cur_hi(cur_hi), .pump_off(pump_off), .drv_dis(drv_dis),
    .test_en(test_en), .p6_drv(p6_drv), .p7_drv(p7_drv), .pump_up(pump_up),
    .pump_dn(pump_dn), .cp_hi(cp_hi), .drv_off(drv_off), .p6_out(p6_out),
    .p7_out(p7_out), .locked(locked));

  int n_checks = 0, n_fail = 0;
  int cyc, lo_per;
  int p6_at, p7_at, p6_gap, n_gaps, up_dn_diff, pump_act, port_diff;
  bit have_p6, have_p7;
  int gaps [0:7];

  // {oscillator strobe period, ratio, expected lock}
  localparam int ROWS = 6;
  localparam int VEC [ROWS][3] = '{
    '{1, 8, 1}, '{2, 4, 1}, '{4, 2, 1},
    '{1, 9, 0}, '{1, 7, 0}, '{2, 5, 0}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lo_tick = 0; ref_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; have_p6 = 0; have_p7 = 0; n_gaps = 0; p6_gap = 0;
    up_dn_diff = 0; pump_act = 0; port_diff = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (p7_out && test_en) begin
        if (have_p7 && n_gaps < 8) begin gaps[n_gaps] = cyc - p7_at; n_gaps++; end
        p7_at = cyc; have_p7 = 1;
      end
      if (p6_out && test_en) begin
        if (have_p6) p6_gap = cyc - p6_at;
        p6_at = cyc; have_p6 = 1;
      end
      if (pump_up != pump_dn) up_dn_diff++;
      if (pump_up || pump_dn) pump_act++;
      if (!test_en && (p6_out != p6_drv || p7_out != p7_drv)) port_diff++;
      lo_tick  = ((cyc % lo_per) == lo_per - 1);
      ref_tick = 1'b1;
      cyc++;
    end
  endtask

  initial begin
    #2000000;
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    lo_per = 1;
    // R10: reset state
    rst_n = 1'b0; p6_drv = 1; p7_drv = 0;
    repeat (3) @(negedge clk);
    check(!pump_up && !pump_dn && !locked, "R10 reset outputs", {pump_up, pump_dn, locked}, 0);

    // R8 / R4: table of alignment scenarios
    for (int r = 0; r < ROWS; r++) begin
      lo_per = VEC[r][0]; n_ratio = 15'(VEC[r][1]);
      do_reset();
      run(150);
      check(locked == VEC[r][2][0], $sformatf("R8 lock row %0d", r), locked, VEC[r][2]);
      if (VEC[r][2] == 1)
        check(up_dn_diff == 0, $sformatf("R4 same-cycle events row %0d", r), up_dn_diff, 0);
    end

    // R7 pass-through seen during the table runs (test_en low)
    check(port_diff == 0, "R7 ports pass through", port_diff, 0);

    // R9: locked loop loses lock after a ratio change
    lo_per = 1; n_ratio = 15'd8;
    do_reset(); run(100);
    check(locked == 1'b1, "R8 locked before step", locked, 1);
    n_ratio = 15'd12;
    run(60);
    check(locked == 1'b0, "R9 lock lost after step", locked, 0);

    // R5: pump disabled on a mismatched loop, then enabled
    n_ratio = 15'd9; pump_off = 1;
    do_reset(); run(120);
    check(pump_act == 0, "R5 pump off silences requests", pump_act, 0);
    pump_off = 0;
    do_reset(); run(120);
    check(pump_act > 0, "R5 pump on issues requests", pump_act, 1);

    // R6 level controls
    cur_hi = 1; drv_dis = 1; @(negedge clk);
    check(cp_hi && drv_off, "R6 high current and drive off", {cp_hi, drv_off}, 3);
    cur_hi = 0; drv_dis = 0; @(negedge clk);
    check(!cp_hi && !drv_off, "R6 low current and drive on", {cp_hi, drv_off}, 0);

    // R7 / R1: test routing and reference period
    test_en = 1; n_ratio = 15'd8;
    do_reset(); run(40);
    check(p6_gap == REF_DIV, "R1 comparison period on p6", p6_gap, REF_DIV);
    check(n_gaps > 0 && gaps[0] == 8, "R7 divided event on p7", gaps[0], 8);

    // R3: ratio change mid-period applies only after terminal count
    do_reset(); run(12);
    n_gaps = 0; n_ratio = 15'd5;
    run(30);
    check(gaps[0] == 8, "R3 period in progress kept", gaps[0], 8);
    check(gaps[1] == 5, "R3 new ratio after terminal", gaps[1], 5);

    // R2: ratios below two act as two
    n_ratio = 15'd1;
    do_reset(); run(20);
    check(n_gaps > 1 && gaps[1] == 2, "R2 ratio 1 divides by 2", gaps[1], 2);
    n_ratio = 15'd0;
    do_reset(); run(20);
    check(n_gaps > 1 && gaps[1] == 2, "R2 ratio 0 divides by 2", gaps[1], 2);
    n_ratio = 15'd3; lo_per = 2;
    do_reset(); run(40);
    check(n_gaps > 1 && gaps[1] == 6, "R2 ratio 3 at half strobe rate", gaps[1], 6);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule